// File: doc/BRIEF.md
# Compare Match Timer

A multi-channel interval timer on a simple synchronous register bus. Each channel owns an up-counter, a compare register and a control/status word. The counter advances on ticks from a shared free-running prescaler. The control word selects one of four tick rates, a restart-on-compare mode and a routing for the match event. A single run register at offset zero holds one run bit per channel and gates all of them.

A counter equal to its compare value on a tick sets a sticky match flag. In periodic mode the counter then restarts from zero, so the period is compare+1 ticks. In free-running mode it keeps counting. A wrap from all ones to zero without a match sets a sticky overflow flag. Software clears a flag by writing zero to its bit; writing one leaves the flag as it is. A write to the counter lands only after a fixed delay of input clocks, and a busy bit is visible for that whole interval. Each channel drives a level interrupt.

Top module: `cmt_timer`

## Requirements
- R1: After reset every register reads zero, all run bits are clear and every interrupt output is low.
- R2: The run register sits at byte offset 0x00, with bit i as the run bit of channel i. Channel i's block starts at byte 0x10+0x10*i, with status/control at +0x0, counter at +0x4 and compare at +0x8. All registers are 32-bit words, and any other address reads zero.
- R3: Status bits 2:0 pick the tick source: 100 gives one tick every 8 clocks, 101 every 32, 110 every 128 and 111 every clock. Codes 000 to 011 give no ticks.
- R4: With the mode bit (bit 8) set, a tick that finds counter equal to compare loads zero and sets the match flag (bit 15). The period is compare+1 ticks.
- R5: With the mode bit clear, a compare match sets the match flag and the counter keeps counting upward.
- R6: A tick that wraps the counter from all ones to zero without a compare match sets the overflow flag (bit 14).
- R7: The match and overflow flags are sticky. A status write with 0 in a flag's bit clears that flag, and a write with 1 leaves it unchanged.
- R8: A counter write loads the value LOAD_DELAY (default 3) clocks after the write edge. Busy bit 13 reads 1 until then, and a counter write issued while busy is ignored.
- R9: A channel whose run bit is clear holds its counter.
- R10: The channel's interrupt output is high exactly while the match flag is set and routing bits 5:4 equal 10. Routing 00 (none) and 01 (DMA request) keep it low.
- R11: Of the status word, only bits 8, 5:4 and 2:0 are writable. Bits 15, 14 and 13 are read-only apart from the clearing rule, and all other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | NUM_CH | Per-channel level interrupt |

## Verification
The bench loads the counter with two values in consecutive cycles. A design that accepts the second write while busy, or loads on the wrong edge, returns the wrong count or the wrong busy bit. Prescaler rates are checked over windows of an exact multiple of the division, so a wrong divider yields a wrong count regardless of prescaler phase. The bench runs a wrap from all ones against a distant compare value; this catches a design that sets the match flag instead of overflow or does not wrap. It also checks flag clearing with one flag written 0 and the other 1; a design that toggles on write, or clears both flags, leaves the wrong status word. The interrupt is checked under DMA routing, where a design that ignores routing would raise it.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int PRE_W   = 7;
  localparam int B_MATCH = 15;
  localparam int B_OVF   = 14;
  localparam int B_BUSY  = 13;
  localparam int B_MODE  = 8;

  localparam logic [1:0] ROUTE_IRQ = 2'b10;

  // Tick strobe for a clock-select code, given the free-running prescaler.
  function automatic logic tick_sel(input logic [2:0] sel, input logic [PRE_W-1:0] pre);
    case (sel)
      3'b100:  return &pre[2:0];
      3'b101:  return &pre[4:0];
      3'b110:  return &pre;
      3'b111:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Counter value after one tick.
  function automatic logic [31:0] next_count(input logic [31:0] cnt, input logic [31:0] cmp,
                                             input logic periodic);
    if (periodic && cnt == cmp) return '0;
    return cnt + 32'd1;
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [PRE_W-1:0] pre
);
  always_ff @(posedge clk) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;
  end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int LOAD_DELAY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic             csr_we,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic             wr_keep_m,
  input  logic             wr_keep_o,
  input  logic             wr_mode,
  input  logic [1:0]       wr_route,
  input  logic [2:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_val,
  output logic [15:0]      csr_rd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             irq,
  output logic             match_ev,
  output logic             wrap_ev,
  output logic             load_ev,
  output logic             busy,
  output logic             flag_m,
  output logic             flag_o,
  output logic             mode
);
  localparam int DLY_W = $clog2(LOAD_DELAY + 1);

  logic [1:0]       route;
  logic [2:0]       sel;
  logic [DLY_W-1:0] dly;
  logic [CNT_W-1:0] pend;
  logic             tick;
  logic             at_cmp;
  logic             at_top;

  assign tick     = run && tick_sel(sel, pre);
  assign at_cmp   = (cnt_q == cmp_q);
  assign at_top   = &cnt_q;
  assign match_ev = tick && at_cmp;
  assign wrap_ev  = tick && at_top && !at_cmp;
  assign busy     = (dly != '0);
  assign load_ev  = (dly == DLY_W'(1));
  assign irq      = flag_m && (route == ROUTE_IRQ);
  assign csr_rd   = {flag_m, flag_o, busy, 4'b0, mode, 2'b0, route, 1'b0, sel};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= 1'b0;
      route <= '0;
      sel   <= '0;
      cmp_q <= '0;
    end else begin
      if (csr_we) begin
        mode  <= wr_mode;
        route <= wr_route;
        sel   <= wr_sel;
      end
      if (cmp_we) cmp_q <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly  <= '0;
      pend <= '0;
    end else if (cnt_we && !busy) begin
      dly  <= DLY_W'(LOAD_DELAY);
      pend <= wr_val;
    end else if (busy) begin
      dly  <= dly - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load_ev) cnt_q <= pend;
    else if (tick)    cnt_q <= CNT_W'(next_count(32'(cnt_q), 32'(cmp_q), mode));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_m <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (match_ev)                    flag_m <= 1'b1;
      else if (csr_we && !wr_keep_m)   flag_m <= 1'b0;
      if (wrap_ev)                     flag_o <= 1'b1;
      else if (csr_we && !wr_keep_o)   flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int CNT_W      = 32,
  parameter int LOAD_DELAY = 3,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int BLK_W = ADDR_W - 4;

  logic [PRE_W-1:0]        pre;
  logic [NUM_CH-1:0]       run_q;
  logic                    start_hit;
  logic [NUM_CH-1:0]       ch_hit;
  logic [NUM_CH-1:0]       match_ev, wrap_ev, load_ev, busy_v, flag_m, flag_o, mode_v;
  logic [NUM_CH*CNT_W-1:0] cnt_flat;
  logic [15:0]             csr_a [NUM_CH];
  logic [CNT_W-1:0]        cnt_a [NUM_CH];
  logic [CNT_W-1:0]        cmp_a [NUM_CH];

  cmt_prescaler u_pre (.clk(clk), .rst_n(rst_n), .pre(pre));

  assign start_hit = (bus_addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                  run_q <= '0;
    else if (bus_we && start_hit) run_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic word_ok;
    assign word_ok   = (bus_addr[1:0] == 2'b00);
    assign ch_hit[i] = (bus_addr[ADDR_W-1:4] == BLK_W'(i + 1)) && word_ok;

    cmt_channel #(.CNT_W(CNT_W), .LOAD_DELAY(LOAD_DELAY)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q[i]),
      .pre      (pre),
      .csr_we   (bus_we && ch_hit[i] && bus_addr[3:2] == 2'd0),
      .cnt_we   (bus_we && ch_hit[i] && bus_addr[3:2] == 2'd1),
      .cmp_we   (bus_we && ch_hit[i] && bus_addr[3:2] == 2'd2),
      .wr_keep_m(bus_wdata[B_MATCH]),
      .wr_keep_o(bus_wdata[B_OVF]),
      .wr_mode  (bus_wdata[B_MODE]),
      .wr_route (bus_wdata[5:4]),
      .wr_sel   (bus_wdata[2:0]),
      .wr_val   (bus_wdata[CNT_W-1:0]),
      .csr_rd   (csr_a[i]),
      .cnt_q    (cnt_a[i]),
      .cmp_q    (cmp_a[i]),
      .irq      (irq[i]),
      .match_ev (match_ev[i]),
      .wrap_ev  (wrap_ev[i]),
      .load_ev  (load_ev[i]),
      .busy     (busy_v[i]),
      .flag_m   (flag_m[i]),
      .flag_o   (flag_o[i]),
      .mode     (mode_v[i])
    );
    assign cnt_flat[i*CNT_W +: CNT_W] = cnt_a[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (start_hit) bus_rdata = 32'(run_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) begin
        case (bus_addr[3:2])
          2'd0:    bus_rdata = 32'(csr_a[i]);
          2'd1:    bus_rdata = 32'(cnt_a[i]);
          2'd2:    bus_rdata = 32'(cmp_a[i]);
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       match_ev,
  input logic [NUM_CH-1:0]       wrap_ev,
  input logic [NUM_CH-1:0]       load_ev,
  input logic [NUM_CH-1:0]       busy_v,
  input logic [NUM_CH-1:0]       flag_m,
  input logic [NUM_CH-1:0]       flag_o,
  input logic [NUM_CH-1:0]       mode_v,
  input logic [NUM_CH-1:0]       run_q,
  input logic [NUM_CH*CNT_W-1:0] cnt_flat
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    assert_periodic_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      match_ev[i] && mode_v[i] && !load_ev[i] |=> cnt_flat[i*CNT_W +: CNT_W] == '0);
    assert_match_flag_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_m[i]) |-> $past(match_ev[i]));
    assert_ovf_flag_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o[i]) |-> $past(wrap_ev[i]));
    assert_busy_ends_in_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_v[i]) |-> $past(load_ev[i]));
    assert_stopped_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q[i] && !load_ev[i] |=> $stable(cnt_flat[i*CNT_W +: CNT_W]));
  end
endmodule

bind cmt_timer cmt_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .match_ev(match_ev), .wrap_ev(wrap_ev), .load_ev(load_ev),
  .busy_v(busy_v), .flag_m(flag_m), .flag_o(flag_o), .mode_v(mode_v), .run_q(run_q),
  .cnt_flat(cnt_flat)
);

// File: tb/tb_cmt_timer.sv
module tb_cmt_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  cmt_timer dut (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
                 .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // loads ch0 counter and waits for the load to land
  task automatic load0(input logic [31:0] v);
    wr(8'h14, v);
    idle(3);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R1 run reg", d, 0);
    rd(8'h10, d); chk("R1 ch0 csr", d, 0);
    rd(8'h18, d); chk("R1 ch0 cmp", d, 0);
    rd(8'h24, d); chk("R1 ch1 cnt", d, 0);
    chk("R1 irq", 32'(irq), 0);
    rd(8'h0C, d); chk("R2 unmapped", d, 0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R11 writable bits / R7 write-1 keeps", d, 32'h0000_0137);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_load();
    logic [31:0] d;
    wr(8'h14, 32'h1234);
    rd(8'h10, d); chk("R8 busy set", d, 32'h0000_2000);
    wr(8'h14, 32'h5555);
    rd(8'h14, d); chk("R8 not yet loaded", d, 0);
    idle(2);
    rd(8'h14, d); chk("R8 first value loaded", d, 32'h1234);
    rd(8'h10, d); chk("R8 busy clear", d, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    wr(8'h10, 32'h0127); wr(8'h18, 4); load0(0);
    wr(8'h00, 1); idle(11); wr(8'h00, 0);
    rd(8'h14, d); chk("R4 count 12 ticks mod 5", d, 2);
    rd(8'h10, d); chk("R4 match flag", d, 32'h8127);
    chk("R10 irq high", 32'(irq), 1);
    wr(8'h10, 32'h4127);
    rd(8'h10, d); chk("R7 match cleared", d, 32'h0127);
    chk("R10 irq low after clear", 32'(irq), 0);
  endtask

  task automatic t_freerun();
    logic [31:0] d;
    wr(8'h10, 32'h0027); wr(8'h18, 3); load0(0);
    wr(8'h00, 1); idle(5); wr(8'h00, 0);
    rd(8'h14, d); chk("R5 counts past compare", d, 6);
    rd(8'h10, d); chk("R5 match flag", d, 32'h8027);
    wr(8'h10, 32'h0027);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    wr(8'h10, 32'h0007); wr(8'h18, 5); load0(32'hFFFF_FFFE);
    wr(8'h00, 1); idle(2); wr(8'h00, 0);
    rd(8'h14, d); chk("R6 wrapped count", d, 1);
    rd(8'h10, d); chk("R6 overflow only", d, 32'h4007);
    idle(20);
    rd(8'h14, d); chk("R9 frozen when stopped", d, 1);
    wr(8'h10, 32'h8007);
    rd(8'h10, d); chk("R7 overflow cleared", d, 32'h0007);
  endtask

  task automatic t_prescale(input logic [2:0] sel, input int edges, input int exp);
    logic [31:0] d;
    wr(8'h10, 32'(sel)); wr(8'h18, 32'hFFFF_FFFF); load0(0);
    wr(8'h00, 1); idle(edges - 1); wr(8'h00, 0);
    rd(8'h14, d); chk($sformatf("R3 select %b", sel), d, 32'(exp));
  endtask

  task automatic t_ch1();
    logic [31:0] d;
    wr(8'h20, 32'h0117); wr(8'h28, 2);
    wr(8'h00, 2);
    rd(8'h00, d); chk("R2 run reg readback", d, 2);
    idle(4); wr(8'h00, 0);
    rd(8'h24, d); chk("R2 ch1 count", d, 2);
    rd(8'h20, d); chk("R2 ch1 flag", d, 32'h8117);
    chk("R10 DMA routing keeps irq low", 32'(irq), 0);
    rd(8'h14, d); chk("R9 ch0 untouched", d, 0);
    wr(8'h20, 32'hC127);
    chk("R10 irq after routing change", 32'(irq), 2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_fields();
    t_load();
    t_periodic();
    t_freerun();
    t_overflow();
    t_prescale(3'b100, 64, 8);
    t_prescale(3'b101, 128, 4);
    t_prescale(3'b110, 256, 2);
    t_prescale(3'b000, 16, 0);
    t_ch1();
    finish_run();
  end
endmodule